// File: doc/BRIEF.md
# Fractional Pulse Swallower (16 of 25)

This block thins a stream of input pulses so that, out of every 25 pulses that arrive, 16 are passed on and 9 are dropped. The output rate is 0.64 times the input rate, which is the same as dividing by 1.5625. It is meant to follow a fixed power-of-two prescaler, so that a divide by 64 becomes a round divide by 100. It is intended for pulse rates up to 50 MHz.

The block runs on the system clock. The input pulse arrives as a one-cycle enable, `pulse_in`. The output is a registered one-cycle enable, `pass_stb`, for downstream logic, and is never used as a gated clock. Inside, a free-running position counter from 0 to 24 is kept as two base-5 digits. The high digit is `hi` and the low digit is `lo`. Position p has hi = p / 5 and lo = p mod 5.

Each pulse is passed or dropped by decoding those two digits. A pulse is dropped when `lo` is odd, except for the one position hi = 4, lo = 3, which is let through. This spreads the nine dropped pulses across the cycle, so they never come in a burst.

Top module: `pulse_swallow_16of25`

## Requirements
- R1: While `rst` is high at a rising clock edge, both digits return to 0 and `pass_stb` is 0 in the following cycle.
- R2: Each digit stays within 0..4. `lo` steps by one per pulse and wraps from 4 to 0, carrying one step into `hi`. After position 24 the next pulse brings the counter back to position 0.
- R3: The counter advances on every input pulse, whether that pulse is passed or dropped. It holds its value in any cycle without a pulse.
- R4: `pass_stb` is high in the cycle after a passed pulse and low in every other cycle. It is never high unless `pulse_in` was high in the cycle before.
- R5: A pulse at position p is dropped when p mod 5 is 1 or 3, except for p = 23, which is passed. The dropped positions are 1, 3, 6, 8, 11, 13, 16, 18 and 21.
- R6: Over every 25 consecutive pulses counted from reset, exactly 16 strobes appear.
- R7: Two pulses in a row are never both dropped, whatever the idle gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pulse_in | input | 1 | One-cycle enable marking an input pulse |
| pass_stb | output | 1 | Registered one-cycle enable for each passed pulse |

## Verification
The assertions assume that `rst` is asserted at the first clock edge, so that the digits hold known values before any clocked check becomes active. They also assume that `pulse_in` is a clean level sampled once per clock, with no pulse shorter than a cycle.

The stimulus raises `rst` from time zero. It drives `pulse_in` only away from the rising edge, and mixes three kinds of input: back-to-back pulses, sparse pulses with idle gaps, and a reset in the middle of a 25-pulse window. This exercises the hold behaviour, the carry into the high digit and the recovery from reset.

// File: rtl/pswl_pkg.sv
package pswl_pkg;
  // Radix of each position digit; two digits give RADIX*RADIX positions.
  localparam int unsigned PSWL_RADIX = 5;
  localparam int unsigned PSWL_DW    = $clog2(PSWL_RADIX);

  typedef logic [PSWL_DW-1:0] pswl_digit_t;
endpackage

// File: rtl/pswl_digit.sv
module pswl_digit #(
  parameter int unsigned RADIX = 5,
  localparam int unsigned DW = $clog2(RADIX)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [DW-1:0] value,
  output logic          carry
);
  localparam logic [DW-1:0] TOP = DW'(RADIX - 1);

  assign carry = step && (value == TOP);

  always_ff @(posedge clk) begin
    if (rst)
      value <= '0;
    else if (step)
      value <= (value == TOP) ? '0 : value + 1'b1;
  end

  // R2: digit never leaves its range
  assert_digit_range_R2: assert property (@(posedge clk) disable iff (rst)
    value <= TOP);

  // R2: ordinary step
  assert_digit_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step && value != TOP) |=> value == $past(value) + 1'b1);

  // R2: wrap from top to zero
  assert_digit_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (step && value == TOP) |=> value == '0);

  // R3: holds without a step
  assert_digit_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(value));
endmodule

// File: rtl/pswl_decode.sv
module pswl_decode #(
  parameter int unsigned RADIX   = 5,
  parameter int unsigned KEEP_HI = 4,
  parameter int unsigned KEEP_LO = 3,
  localparam int unsigned DW = $clog2(RADIX)
) (
  input  logic [DW-1:0] hi,
  input  logic [DW-1:0] lo,
  output logic          pass
);
  localparam logic [DW-1:0] KHI = DW'(KEEP_HI);
  localparam logic [DW-1:0] KLO = DW'(KEEP_LO);

  logic odd_lo;
  logic rescue;

  always_comb begin
    odd_lo = lo[0];
    rescue = (hi == KHI) && (lo == KLO);
    pass   = !odd_lo || rescue;
  end
endmodule

// File: rtl/pulse_swallow_16of25.sv
module pulse_swallow_16of25
  import pswl_pkg::*;
#(
  parameter int unsigned KEEP_HI = PSWL_RADIX - 1,
  parameter int unsigned KEEP_LO = PSWL_RADIX - 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_in,
  output logic pass_stb
);
  localparam int unsigned NDIG = 2;

  pswl_digit_t dig   [NDIG];
  logic        carry [NDIG];
  logic        step  [NDIG];
  logic        pass_now;

  assign step[0] = pulse_in;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    if (g > 0) begin : g_chain
      assign step[g] = carry[g-1];
    end
    pswl_digit #(.RADIX(PSWL_RADIX)) u_digit (
      .clk   (clk),
      .rst   (rst),
      .step  (step[g]),
      .value (dig[g]),
      .carry (carry[g])
    );
  end

  pswl_decode #(
    .RADIX   (PSWL_RADIX),
    .KEEP_HI (KEEP_HI),
    .KEEP_LO (KEEP_LO)
  ) u_decode (
    .hi   (dig[NDIG-1]),
    .lo   (dig[0]),
    .pass (pass_now)
  );

  always_ff @(posedge clk) begin
    if (rst) pass_stb <= 1'b0;
    else     pass_stb <= pulse_in && pass_now;
  end

  // Checker state: whether the last pulse was dropped.
  logic last_dropped;
  always_ff @(posedge clk) begin
    if (rst)           last_dropped <= 1'b0;
    else if (pulse_in) last_dropped <= !pass_now;
  end

  // R1: reset clears digits and strobe
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!pass_stb && dig[0] == '0 && dig[NDIG-1] == '0));

  // R4: a strobe always follows a pulse
  assert_strobe_needs_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    pass_stb |-> $past(pulse_in));

  // R2: full cycle returns to position zero
  assert_cycle_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && dig[0] == pswl_digit_t'(PSWL_RADIX-1)
              && dig[NDIG-1] == pswl_digit_t'(PSWL_RADIX-1))
    |=> (dig[0] == '0 && dig[NDIG-1] == '0));

  // R7: no two dropped pulses in a row
  assert_no_double_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_in && last_dropped) |-> pass_now);
endmodule

// File: tb/pulse_swallow_16of25_tb.sv
module pulse_swallow_16of25_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pulse_in = 1'b0;
  logic pass_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int  pos = 0;
  logic exp_stb = 1'b0;
  bit  prev_pulse = 0;
  bit  prev_rst = 1;
  int  win_pulses = 0;
  int  win_strobes = 0;
  int  drop_run = 0;

  int dropped_q[$] = '{1, 3, 6, 8, 11, 13, 16, 18, 21};

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_swallow_16of25 u_dut (
    .clk      (clk),
    .rst      (rst),
    .pulse_in (pulse_in),
    .pass_stb (pass_stb)
  );

  function automatic bit is_passed(int p);
    foreach (dropped_q[i]) if (dropped_q[i] == p) return 0;
    return 1;
  endfunction

  task automatic step_cycle(input logic r, input logic p);
    @(negedge clk);
    checks++;
    if (pass_stb !== exp_stb) begin
      errors++;
      if (prev_rst)
        $display("FAIL R1 reset strobe: actual %b expected %b", pass_stb, exp_stb);
      else if (prev_pulse)
        $display("FAIL R5 R4 strobe at position %0d: actual %b expected %b",
                 (pos + 24) % 25, pass_stb, exp_stb);
      else
        $display("FAIL R3 R4 idle cycle strobe: actual %b expected %b", pass_stb, exp_stb);
    end
    if (prev_pulse) begin
      if (pass_stb === 1'b1) begin win_strobes++; drop_run = 0; end
      else drop_run++;
      checks++;
      if (drop_run > 1) begin
        errors++;
        $display("FAIL R7 consecutive dropped pulses: actual %0d expected <=1", drop_run);
      end
      win_pulses++;
      if (win_pulses == 25) begin
        checks++;
        if (win_strobes != 16) begin
          errors++;
          $display("FAIL R6 strobes per 25 pulses: actual %0d expected 16", win_strobes);
        end
        win_pulses = 0;
        win_strobes = 0;
      end
    end
    rst = r;
    pulse_in = p;
    prev_rst = r;
    prev_pulse = p && !r;
    if (r) begin
      pos = 0; exp_stb = 1'b0;
      win_pulses = 0; win_strobes = 0; drop_run = 0;
    end else if (p) begin
      exp_stb = is_passed(pos);
      pos = (pos + 1) % 25;
    end else begin
      exp_stb = 1'b0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step_cycle(1'b1, 1'b0);
    // R5 R6: back-to-back pulses across three full cycles
    for (int i = 0; i < 75; i++) step_cycle(1'b0, 1'b1);
    // R3: idle gaps must not advance the position
    for (int i = 0; i < 120; i++) step_cycle(1'b0, (i % 3) != 0);
    // R1: reset in the middle of a window
    for (int i = 0; i < 10; i++) step_cycle(1'b0, 1'b1);
    step_cycle(1'b1, 1'b1);
    step_cycle(1'b1, 1'b0);
    // R2 R7: mixed gaps with long runs, wrapping many times
    for (int i = 0; i < 400; i++) step_cycle(1'b0, ((i % 7) != 6) && ((i % 11) != 3));
    // R2: position 24 wraps to 0 with long idle before the pulse
    for (int i = 0; i < 60; i++) begin
      step_cycle(1'b0, 1'b1);
      step_cycle(1'b0, 1'b0);
      step_cycle(1'b0, 1'b0);
    end
    step_cycle(1'b0, 1'b0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule